// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave control port that fills a small bank of 8-bit configuration registers from a serial host. Three pins are shared: a serial clock, a serial data line and a select pin. Out of reset the port speaks the two-wire I2C protocol. In that mode the select pin supplies one bit of the device address, and the port answers both writes and reads. The first falling edge seen on the select pin after reset switches the port to a three-wire, write-only SPI mode, in which the same pin acts as an active-low chip select. The port stays in SPI mode until the next reset.

In both modes a transfer carries a device address byte, then a pointer byte, then data bytes. The pointer holds a 7-bit register address in bits 6:0, and bit 7 is the step flag. With the step flag set, the pointer moves to the next register after every data byte, so the host can write or read a block of registers. With it clear, every byte of the transfer goes to the same register. The register contents leave the block as one flat parallel bus.

All pin inputs are oversampled on the system clock through two-flop synchronizers. I2C START and STOP conditions are found from data-line edges that occur while the clock line is high. The data line is modelled as open drain: the block only asserts an enable that pulls the line low.

Top module: `regport_top`

## Requirements
- R1: After reset every register reads 0x00, the data-line pull-down enable is low and the port is in I2C mode.
- R2: In I2C mode the address byte is 0,0,1,0,0,0, then the select pin level, then R/W (1 = read), sent MSB first. On a match the port pulls the data line low during the ninth clock. The same low acknowledge follows every pointer and data byte of a write.
- R3: When the upper seven address bits do not match, the port does not acknowledge. It writes nothing and stays silent until the next START.
- R4: In a write, the byte after the address is the pointer, and each data byte after it is stored in the register selected by pointer bits 6:0.
- R5: With pointer bit 7 set, the pointer moves up by one after each data byte, in writes and in reads.
- R6: With pointer bit 7 clear, the pointer does not move. Successive data bytes overwrite one register, and successive reads return that register again.
- R7: An address byte with R/W = 1 starts a read. The port shifts out the register at the current pointer, MSB first, pulling the line low for 0 bits. A host acknowledge (line low) requests the next byte. A host non-acknowledge ends the read.
- R8: Writes to register addresses at or above the bank size are acknowledged but change nothing. Reads of such addresses return 0x00.
- R9: A falling edge on the select pin after reset puts the port into SPI mode for good. From then on I2C traffic is ignored and the pull-down enable stays low.
- R10: An SPI frame is the select pin held low, a chip byte equal to 0x20, a pointer byte, and then data bytes, all sampled on rising clock edges MSB first. A frame whose chip byte differs writes nothing. Raising the select pin ends the frame.
- R11: A repeated START in the middle of a write aborts the current transfer and starts a fresh address and pointer sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling and all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_clk_i | input | 1 | Serial clock (I2C clock or SPI clock) |
| ctl_dat_i | input | 1 | Serial data line as seen on the pad |
| ctl_dat_oe_o | output | 1 | Pull-down enable for the open-drain data line |
| ctl_sel_i | input | 1 | Address bit in I2C mode, active-low chip select in SPI mode |
| regs_o | output | NUM_REGS*8 | Register bank contents, register n in bits 8n+7:8n |

## Verification
The bench drives pointer-step writes that run past the last register. A design that wrapped the address or stored those bytes would corrupt low registers, and one that refused the acknowledge would stall the host. It also performs fixed-pointer writes and reads, where an engine that stepped anyway would spill into the neighbouring register. An address mismatch followed by data bytes would catch an engine that resumed decoding without a START, and a repeated START mid-write would catch one that kept the old pointer. After the switch to SPI, the bench sends a frame with a wrong chip byte and then full I2C traffic. A port that was still partly in I2C mode would acknowledge on the data line or accept those writes.

// File: rtl/regport_pkg.sv
package regport_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_MAP,
    ST_MAP_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } i2c_st_t;

  // Pointer step rule: bit 7 set means advance the 7-bit address field.
  function automatic logic [7:0] map_step(input logic [7:0] m);
    return m[7] ? {1'b1, m[6:0] + 7'd1} : m;
  endfunction

endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int            W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/regport_i2c.sv
module regport_i2c
  import regport_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       ad_i,
  input  logic [7:0] rd_data_i,
  output logic       oe_o,
  output logic       we_o,
  output logic [6:0] addr_o,
  output logic [7:0] wr_data_o
);
  i2c_st_t     st_q, st_d;
  logic [7:0]  sh_q, sh_d;
  logic [3:0]  cnt_q, cnt_d;
  logic [7:0]  ptr_q, ptr_d;
  logic        rw_q, rw_d;
  logic        oe_q, oe_d;
  logic        mack_q, mack_d;
  logic        scl_q, sda_q;
  logic        start, stop, rise, fall;

  assign start = scl_i & scl_q & sda_q & ~sda_i;
  assign stop  = scl_i & scl_q & ~sda_q & sda_i;
  assign rise  = scl_i & ~scl_q;
  assign fall  = ~scl_i & scl_q;

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    rw_d   = rw_q;
    oe_d   = oe_q;
    mack_d = mack_q;
    we_o   = 1'b0;
    if (!en_i) begin
      st_d  = ST_IDLE;
      oe_d  = 1'b0;
      cnt_d = '0;
    end else if (start) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (rise) begin
      case (st_q)
        ST_ADDR, ST_MAP, ST_WR: begin
          if (cnt_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_i};
            cnt_d = cnt_q + 4'd1;
          end
        end
        ST_RD:     cnt_d  = cnt_q + 4'd1;
        ST_RD_ACK: mack_d = ~sda_i;
        default: ;
      endcase
    end else if (fall) begin
      case (st_q)
        ST_ADDR: if (cnt_q == 4'd8) begin
          cnt_d = '0;
          if (sh_q[7:1] == {DEV_ID, ad_i}) begin
            oe_d = 1'b1;
            rw_d = sh_q[0];
            st_d = ST_ADDR_ACK;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_MAP: if (cnt_q == 4'd8) begin
          cnt_d = '0;
          ptr_d = sh_q;
          oe_d  = 1'b1;
          st_d  = ST_MAP_ACK;
        end
        ST_WR: if (cnt_q == 4'd8) begin
          cnt_d = '0;
          we_o  = 1'b1;
          ptr_d = map_step(ptr_q);
          oe_d  = 1'b1;
          st_d  = ST_WR_ACK;
        end
        ST_ADDR_ACK: begin
          if (rw_q) begin
            sh_d = rd_data_i;
            oe_d = ~rd_data_i[7];
            st_d = ST_RD;
          end else begin
            oe_d = 1'b0;
            st_d = ST_MAP;
          end
        end
        ST_MAP_ACK, ST_WR_ACK: begin
          oe_d = 1'b0;
          st_d = ST_WR;
        end
        ST_RD: begin
          if (cnt_q == 4'd8) begin
            cnt_d = '0;
            oe_d  = 1'b0;
            ptr_d = map_step(ptr_q);
            st_d  = ST_RD_ACK;
          end else begin
            sh_d = {sh_q[6:0], 1'b0};
            oe_d = ~sh_q[6];
          end
        end
        ST_RD_ACK: begin
          if (mack_q) begin
            sh_d = rd_data_i;
            oe_d = ~rd_data_i[7];
            st_d = ST_RD;
          end else begin
            st_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
      rw_q   <= 1'b0;
      oe_q   <= 1'b0;
      mack_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      rw_q   <= rw_d;
      oe_q   <= oe_d;
      mack_q <= mack_d;
      scl_q  <= scl_i;
      sda_q  <= sda_i;
    end
  end

  assign oe_o      = oe_q;
  assign addr_o    = ptr_q[6:0];
  assign wr_data_o = sh_q;
endmodule

// File: rtl/regport_spi.sv
module regport_spi
  import regport_pkg::*;
#(
  parameter logic [5:0] DEV_ID = 6'b001000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       we_o,
  output logic [6:0] addr_o,
  output logic [7:0] wr_data_o
);
  logic [6:0] sh_q, sh_d;
  logic [2:0] cnt_q, cnt_d;
  logic [1:0] idx_q, idx_d;
  logic       ok_q, ok_d;
  logic [7:0] ptr_q, ptr_d;
  logic       sck_q;
  logic [7:0] byte_w;
  logic       rise;

  assign rise   = sck_i & ~sck_q;
  assign byte_w = {sh_q, sdi_i};

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    ok_d  = ok_q;
    ptr_d = ptr_q;
    we_o  = 1'b0;
    if (!en_i || cs_n_i) begin
      cnt_d = '0;
      idx_d = '0;
      ok_d  = 1'b0;
    end else if (rise) begin
      sh_d  = byte_w[6:0];
      cnt_d = cnt_q + 3'd1;
      if (cnt_q == 3'd7) begin
        case (idx_q)
          2'd0: begin
            ok_d  = (byte_w == {DEV_ID, 2'b00});
            idx_d = 2'd1;
          end
          2'd1: begin
            if (ok_q) ptr_d = byte_w;
            idx_d = 2'd2;
          end
          default: begin
            if (ok_q) begin
              we_o  = 1'b1;
              ptr_d = map_step(ptr_q);
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      idx_q <= '0;
      ok_q  <= 1'b0;
      ptr_q <= '0;
      sck_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      ok_q  <= ok_d;
      ptr_q <= ptr_d;
      sck_q <= sck_i;
    end
  end

  assign addr_o    = ptr_q[6:0];
  assign wr_data_o = byte_w;
endmodule

// File: rtl/regport_top.sv
module regport_top #(
  parameter int         NUM_REGS = 8,
  parameter logic [5:0] DEV_ID   = 6'b001000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_clk_i,
  input  logic                  ctl_dat_i,
  output logic                  ctl_dat_oe_o,
  input  logic                  ctl_sel_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int         AW    = $clog2(NUM_REGS);
  localparam logic [6:0] NREG7 = 7'(NUM_REGS);

  logic [1:0] rst_pipe;
  logic       rst_n_s;
  logic       scl_s, sda_s, sel_s;
  logic       sel_q, sel_d;
  logic       spi_mode_q, spi_mode_d;
  logic       i2c_we, spi_we, wr_en;
  logic [6:0] i2c_addr, spi_addr, wr_addr;
  logic [7:0] i2c_wd, spi_wd, wr_data, rd_data;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  regport_sync #(.W(2), .RST_VAL(2'b11)) u_sync_bus (
    .clk(clk), .rst_n(rst_n_s),
    .d_i({ctl_clk_i, ctl_dat_i}), .q_o({scl_s, sda_s})
  );
  regport_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sel (
    .clk(clk), .rst_n(rst_n_s), .d_i(ctl_sel_i), .q_o(sel_s)
  );

  // Mode latch: a select fall after reset is sticky.
  always_comb begin
    sel_d      = sel_s;
    spi_mode_d = spi_mode_q | (sel_q & ~sel_s);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sel_q      <= 1'b0;
      spi_mode_q <= 1'b0;
    end else begin
      sel_q      <= sel_d;
      spi_mode_q <= spi_mode_d;
    end
  end

  regport_i2c #(.DEV_ID(DEV_ID)) u_i2c (
    .clk(clk), .rst_n(rst_n_s), .en_i(~spi_mode_q),
    .scl_i(scl_s), .sda_i(sda_s), .ad_i(sel_s),
    .rd_data_i(rd_data), .oe_o(ctl_dat_oe_o),
    .we_o(i2c_we), .addr_o(i2c_addr), .wr_data_o(i2c_wd)
  );

  regport_spi #(.DEV_ID(DEV_ID)) u_spi (
    .clk(clk), .rst_n(rst_n_s), .en_i(spi_mode_q),
    .cs_n_i(sel_s), .sck_i(scl_s), .sdi_i(sda_s),
    .we_o(spi_we), .addr_o(spi_addr), .wr_data_o(spi_wd)
  );

  assign wr_en   = i2c_we | spi_we;
  assign wr_addr = spi_mode_q ? spi_addr : i2c_addr;
  assign wr_data = spi_mode_q ? spi_wd   : i2c_wd;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic       hit;
    logic [7:0] q;
    assign hit = wr_en && (wr_addr == 7'(g));
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s) q <= '0;
      else if (hit) q <= wr_data;
    end
    assign regs_o[g*8 +: 8] = q;
  end

  logic [AW-1:0] rd_idx;
  assign rd_idx  = i2c_addr[AW-1:0];
  assign rd_data = (i2c_addr < NREG7) ? regs_o[{rd_idx, 3'b000} +: 8] : 8'h00;
endmodule

// File: rtl/regport_chk.sv
module regport_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  spi_mode,
  input logic                  sel_q,
  input logic                  sel_s,
  input logic                  scl_s,
  input logic                  oe,
  input logic                  we,
  input logic [6:0]            wa,
  input logic [NUM_REGS*8-1:0] regs
);
  localparam logic [6:0] NREG7 = 7'(NUM_REGS);

  // R9
  spi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode |=> spi_mode);

  // R9
  sel_fall_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel_s) |=> spi_mode);

  // R9
  spi_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_mode && $past(spi_mode)) |-> !oe);

  // R8
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa >= NREG7)) |=> $stable(regs));

  // R2
  ack_on_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> !scl_s);
endmodule

bind regport_top regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .spi_mode(spi_mode_q),
  .sel_q(sel_q), .sel_s(sel_s), .scl_s(scl_s), .oe(ctl_dat_oe_o),
  .we(wr_en), .wa(wr_addr), .regs(regs_o)
);

// File: tb/regport_top_tb.sv
module regport_top_tb;
  localparam int NREG = 8;
  localparam int H    = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n, scl, sda_m, sel, oe, bus, done;
  logic [NREG*8-1:0] regs;
  logic [7:0]      exp_r [NREG];
  int checks = 0;
  int errors = 0;

  assign bus = sda_m & ~oe;

  regport_top #(.NUM_REGS(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_clk_i(scl), .ctl_dat_i(bus),
    .ctl_dat_oe_o(oe), .ctl_sel_i(sel), .regs_o(regs)
  );

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(regs[i*8 +: 8] == exp_r[i], req, 32'(regs[i*8 +: 8]), 32'(exp_r[i]));
  endtask

  task automatic i2c_start();
    w(H/2); sda_m = 1'b1; w(H/2); scl = 1'b1; w(H);
    sda_m = 1'b0; w(H); scl = 1'b0;
  endtask

  task automatic i2c_stop();
    w(H/2); sda_m = 1'b0; w(H/2); scl = 1'b1; w(H);
    sda_m = 1'b1; w(H);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      w(H/2); sda_m = b[i]; w(H/2); scl = 1'b1; w(H); scl = 1'b0;
    end
    w(H/2); sda_m = 1'b1; w(H/2); scl = 1'b1; w(H/2); ack = bus; w(H/2); scl = 1'b0;
    chk(ack == exp_ack, req, 32'(ack), 32'(exp_ack));
  endtask

  task automatic recv(input bit more, input logic [7:0] expv, input string req);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl = 1'b1; w(H/2); b[i] = bus; w(H/2); scl = 1'b0;
    end
    w(H/2); sda_m = ~more; w(H/2); scl = 1'b1; w(H); scl = 1'b0; w(H/2); sda_m = 1'b1;
    chk(b == expv, req, 32'(b), 32'(expv));
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(H); scl = 1'b1; w(H); scl = 1'b0;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    chk_regs("R1");
    chk(oe == 1'b0, "R1", 32'(oe), 0);
  endtask

  task automatic t_single_write();
    i2c_start(); send(8'h22, 1'b0, "R2"); send(8'h03, 1'b0, "R2"); send(8'hA5, 1'b0, "R4");
    i2c_stop(); exp_r[3] = 8'hA5; chk_regs("R4");
  endtask

  task automatic t_block_write();
    i2c_start(); send(8'h22, 0, "R2"); send(8'h85, 0, "R5");
    send(8'h11, 0, "R5"); send(8'h22, 0, "R5"); send(8'h33, 0, "R5"); i2c_stop();
    exp_r[5] = 8'h11; exp_r[6] = 8'h22; exp_r[7] = 8'h33; chk_regs("R5");
  endtask

  task automatic t_fixed_write();
    i2c_start(); send(8'h22, 0, "R2"); send(8'h01, 0, "R6");
    send(8'h44, 0, "R6"); send(8'h55, 0, "R6"); i2c_stop();
    exp_r[1] = 8'h55; chk_regs("R6");
  endtask

  task automatic t_addr_mismatch();
    i2c_start(); send(8'h20, 1'b1, "R3"); send(8'h00, 1'b1, "R3"); send(8'hFF, 1'b1, "R3");
    i2c_stop(); chk_regs("R3");
  endtask

  task automatic t_restart();
    i2c_start(); send(8'h22, 0, "R11"); send(8'h00, 0, "R11"); send(8'h66, 0, "R11");
    i2c_start(); send(8'h22, 0, "R11"); send(8'h04, 0, "R11"); send(8'h77, 0, "R11");
    i2c_stop(); exp_r[0] = 8'h66; exp_r[4] = 8'h77; chk_regs("R11");
  endtask

  task automatic t_out_of_range();
    i2c_start(); send(8'h22, 0, "R8"); send(8'h87, 0, "R8");
    send(8'h99, 0, "R8"); send(8'hBB, 0, "R8"); i2c_stop();
    exp_r[7] = 8'h99; chk_regs("R8");
  endtask

  task automatic t_block_read();
    i2c_start(); send(8'h22, 0, "R7"); send(8'h83, 0, "R7");
    i2c_start(); send(8'h23, 0, "R7");
    recv(1'b1, 8'hA5, "R7"); recv(1'b1, 8'h77, "R5"); recv(1'b0, 8'h11, "R7");
    i2c_stop();
  endtask

  task automatic t_fixed_read();
    i2c_start(); send(8'h22, 0, "R8"); send(8'h10, 0, "R8");
    i2c_start(); send(8'h23, 0, "R8"); recv(1'b0, 8'h00, "R8"); i2c_stop();
    i2c_start(); send(8'h22, 0, "R6"); send(8'h06, 0, "R6");
    i2c_start(); send(8'h23, 0, "R6");
    recv(1'b1, 8'h22, "R6"); recv(1'b0, 8'h22, "R6"); i2c_stop();
  endtask

  task automatic t_spi_write();
    scl = 1'b0; sda_m = 1'b1; w(H); sel = 1'b0; w(H);
    spi_byte(8'h20); spi_byte(8'h80); spi_byte(8'hC1); spi_byte(8'hC2);
    w(H); sel = 1'b1; w(H);
    exp_r[0] = 8'hC1; exp_r[1] = 8'hC2; chk_regs("R10");
  endtask

  task automatic t_spi_bad_addr();
    sel = 1'b0; w(H);
    spi_byte(8'h22); spi_byte(8'h02); spi_byte(8'hDD);
    w(H); sel = 1'b1; w(H);
    chk_regs("R10");
  endtask

  task automatic t_i2c_after_spi();
    sda_m = 1'b1; scl = 1'b1; w(H);
    i2c_start(); send(8'h22, 1'b1, "R9"); send(8'h02, 1'b1, "R9"); send(8'hEE, 1'b1, "R9");
    i2c_stop(); chk_regs("R9");
  endtask

  initial begin
    done = 1'b0;
    rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; sel = 1'b1;
    w(5); rst_n = 1'b1; w(10);
    t_reset();
    t_single_write();
    t_block_write();
    t_fixed_write();
    t_addr_mismatch();
    t_restart();
    t_out_of_range();
    t_block_read();
    t_fixed_read();
    t_spi_write();
    t_spi_bad_addr();
    t_i2c_after_spi();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule